// File: doc/BRIEF.md
# Fused Multiply-Add NaN Selector

This unit sits beside a fused multiply-add datapath computing (a*b)+c. It decides which operand NaN, or a generated default NaN, becomes the result of the operation whenever at least one operand is a NaN. The datapath hands it a class code for each of the three operands, the raw operand words, a rule-set select and the signaling-bit polarity. The unit returns a 2-bit selection code, an invalid-operation flag and the final NaN word. A selected signaling NaN is quieted on the way out.

Whether a product of infinity and zero is present is worked out inside the unit from the classes of a and b. Each rule set treats that case in its own way. The selection and quieting logic is purely combinational. One register stage carries a valid bit alongside the result, so a result appears one clock after its inputs.

Top module: `fma_nan_select`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous clock. The result fields (`out_hit`, `out_sel`, `out_invalid`, `out_result`) load only on a clock where `in_valid` is 1 and hold otherwise.
- R2: Class codes are normal=0, zero=1, infinity=2, quiet NaN=3, signaling NaN=4, and codes 5..7 count as normal. Selection codes are a=0, b=1, c=2, default NaN=3. When no operand is a NaN, the result is `out_hit`=0, `out_sel`=0, `out_invalid`=0 and `out_result`=0. Otherwise `out_hit`=1.
- R3: Rule 0 handles the case where a*b is infinity times zero and c is a quiet NaN: it selects the default NaN and raises invalid. Otherwise rule 0 takes the first NaN in the order: c signaling, a signaling, b signaling, c quiet, a quiet, b quiet.
- R4: Rule 1 with `snan_msb_set`=1: an infinity-times-zero product selects the default NaN and raises invalid. Otherwise the order is signaling a, b, c, then quiet a, b, c.
- R5: Rule 1 with `snan_msb_set`=0: an infinity-times-zero product selects c and raises invalid. Otherwise the order is signaling c, a, b, then quiet c, a, b.
- R6: Rule 2: an infinity-times-zero product selects c and raises invalid. Otherwise it selects a if a is a NaN, else c if c is a NaN, else b.
- R7: Rule 3: a if a is a NaN, else b if b is a NaN, else c. An infinity-times-zero product has no effect under this rule.
- R8: The infinity-times-zero condition holds when one of a, b has class infinity and the other has class zero.
- R9: When any operand is a signaling NaN, `out_invalid` is 1.
- R10: A selected quiet NaN passes through unchanged. A selected signaling NaN is handled according to `snan_msb_set`: when it is 0, the word is kept with the fraction MSB (bit FRAC_W-1) set; when it is 1, the word is replaced by the default NaN.
- R11: The default NaN has sign 0 and an all-ones exponent. Its fraction depends on `snan_msb_set`: when 0, only the fraction MSB is set; when 1, every fraction bit except the MSB is set.
- R12: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set present this clock |
| cls_a | input | 3 | Class code of a |
| cls_b | input | 3 | Class code of b |
| cls_c | input | 3 | Class code of c |
| opnd_a | input | 1+EXP_W+FRAC_W | Operand a word |
| opnd_b | input | 1+EXP_W+FRAC_W | Operand b word |
| opnd_c | input | 1+EXP_W+FRAC_W | Operand c word |
| rule_sel | input | 2 | Rule set 0..3 |
| snan_msb_set | input | 1 | 1: a fraction MSB of 1 marks a signaling NaN |
| out_valid | output | 1 | Registered valid |
| out_hit | output | 1 | Some operand was a NaN |
| out_sel | output | 2 | Selection code |
| out_invalid | output | 1 | Invalid-operation flag |
| out_result | output | 1+EXP_W+FRAC_W | Final NaN word |

## Verification
The bench builds the unit at the single-precision widths, EXP_W=8 and FRAC_W=23. At these widths the quiet bit, the default NaN patterns and the operand words can be written and checked as readable 32-bit hex values. A behavioural reference compares all four result fields every clock. The vectors include directed cases for every rule and polarity combination, for the infinity-times-zero case under each rule, and for out-of-range class codes. A long pseudo-random run mixes classes so that every priority position is reached.

// File: rtl/fnan_pkg.sv
package fnan_pkg;
  localparam int NOPS = 3;
  localparam int IX_A = 0;
  localparam int IX_B = 1;
  localparam int IX_C = 2;

  localparam logic [2:0] CLS_NORM = 3'd0;
  localparam logic [2:0] CLS_ZERO = 3'd1;
  localparam logic [2:0] CLS_INF  = 3'd2;
  localparam logic [2:0] CLS_QNAN = 3'd3;
  localparam logic [2:0] CLS_SNAN = 3'd4;

  localparam logic [1:0] SEL_A    = 2'd0;
  localparam logic [1:0] SEL_B    = 2'd1;
  localparam logic [1:0] SEL_C    = 2'd2;
  localparam logic [1:0] SEL_DFLT = 2'd3;

  localparam logic [1:0] RULE_0 = 2'd0;
  localparam logic [1:0] RULE_1 = 2'd1;
  localparam logic [1:0] RULE_2 = 2'd2;
  localparam logic [1:0] RULE_3 = 2'd3;
endpackage

// File: rtl/fnan_flags.sv
module fnan_flags
  import fnan_pkg::*;
(
  input  logic [NOPS-1:0][2:0] cls,
  output logic [NOPS-1:0]      is_q,
  output logic [NOPS-1:0]      is_s,
  output logic                 infz
);
  for (genvar g = 0; g < NOPS; g++) begin : g_op
    assign is_q[g] = (cls[g] == CLS_QNAN);
    assign is_s[g] = (cls[g] == CLS_SNAN);
  end

  // R8: one multiplicand infinite, the other zero
  assign infz = ((cls[IX_A] == CLS_INF)  && (cls[IX_B] == CLS_ZERO)) ||
                ((cls[IX_A] == CLS_ZERO) && (cls[IX_B] == CLS_INF));
endmodule

// File: rtl/fnan_priority.sv
module fnan_priority
  import fnan_pkg::*;
(
  input  logic [NOPS-1:0] is_q,
  input  logic [NOPS-1:0] is_s,
  input  logic            infz,
  input  logic [1:0]      rule,
  input  logic            pol,
  output logic            hit,
  output logic [1:0]      sel,
  output logic            inv
);
  logic [NOPS-1:0] is_n;
  assign is_n = is_q | is_s;

  always_comb begin
    hit = |is_n;
    sel = SEL_A;
    inv = 1'b0;
    if (hit) begin
      inv = |is_s;
      case (rule)
        RULE_0: begin
          if (infz && is_q[IX_C]) begin
            sel = SEL_DFLT;
            inv = 1'b1;
          end
          else if (is_s[IX_C]) sel = SEL_C;
          else if (is_s[IX_A]) sel = SEL_A;
          else if (is_s[IX_B]) sel = SEL_B;
          else if (is_q[IX_C]) sel = SEL_C;
          else if (is_q[IX_A]) sel = SEL_A;
          else                 sel = SEL_B;
        end
        RULE_1: begin
          if (pol) begin
            if (infz) begin
              sel = SEL_DFLT;
              inv = 1'b1;
            end
            else if (is_s[IX_A]) sel = SEL_A;
            else if (is_s[IX_B]) sel = SEL_B;
            else if (is_s[IX_C]) sel = SEL_C;
            else if (is_q[IX_A]) sel = SEL_A;
            else if (is_q[IX_B]) sel = SEL_B;
            else                 sel = SEL_C;
          end else begin
            if (infz) begin
              sel = SEL_C;
              inv = 1'b1;
            end
            else if (is_s[IX_C]) sel = SEL_C;
            else if (is_s[IX_A]) sel = SEL_A;
            else if (is_s[IX_B]) sel = SEL_B;
            else if (is_q[IX_C]) sel = SEL_C;
            else if (is_q[IX_A]) sel = SEL_A;
            else                 sel = SEL_B;
          end
        end
        RULE_2: begin
          if (infz) begin
            sel = SEL_C;
            inv = 1'b1;
          end
          else if (is_n[IX_A]) sel = SEL_A;
          else if (is_n[IX_C]) sel = SEL_C;
          else                 sel = SEL_B;
        end
        default: begin
          if (is_n[IX_A])      sel = SEL_A;
          else if (is_n[IX_B]) sel = SEL_B;
          else                 sel = SEL_C;
        end
      endcase
    end
  end
endmodule

// File: rtl/fnan_result_mux.sv
module fnan_result_mux
  import fnan_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [NOPS-1:0][EXP_W+FRAC_W:0] opnd,
  input  logic [NOPS-1:0]                 is_s,
  input  logic                            hit,
  input  logic [1:0]                      sel,
  input  logic                            pol,
  output logic [EXP_W+FRAC_W:0]           result
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam logic [WORD_W-1:0] QBIT = WORD_W'(1) << (FRAC_W - 1);

  logic [WORD_W-1:0] dflt;
  logic [WORD_W-1:0] pick;
  logic              pick_s;

  // R11: default NaN pattern per polarity
  assign dflt = {1'b0, {EXP_W{1'b1}},
                 pol ? {1'b0, {(FRAC_W-1){1'b1}}} : {1'b1, {(FRAC_W-1){1'b0}}}};

  always_comb begin
    case (sel)
      SEL_A:   begin pick = opnd[IX_A]; pick_s = is_s[IX_A]; end
      SEL_B:   begin pick = opnd[IX_B]; pick_s = is_s[IX_B]; end
      SEL_C:   begin pick = opnd[IX_C]; pick_s = is_s[IX_C]; end
      default: begin pick = dflt;       pick_s = 1'b0;       end
    endcase
  end

  // R10: quieting of a selected signaling NaN
  always_comb begin
    if (!hit)        result = '0;
    else if (!pick_s) result = pick;
    else if (pol)     result = dflt;
    else              result = pick | QBIT;
  end
endmodule

// File: rtl/fma_nan_select.sv
module fma_nan_select
  import fnan_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        cls_a,
  input  logic [2:0]        cls_b,
  input  logic [2:0]        cls_c,
  input  logic [WORD_W-1:0] opnd_a,
  input  logic [WORD_W-1:0] opnd_b,
  input  logic [WORD_W-1:0] opnd_c,
  input  logic [1:0]        rule_sel,
  input  logic              snan_msb_set,
  output logic              out_valid,
  output logic              out_hit,
  output logic [1:0]        out_sel,
  output logic              out_invalid,
  output logic [WORD_W-1:0] out_result
);
  logic [NOPS-1:0]      is_q, is_s;
  logic                 infz;
  logic                 c_hit, c_inv;
  logic [1:0]           c_sel;
  logic [WORD_W-1:0]    c_res;

  fnan_flags u_flags (
    .cls  ({cls_c, cls_b, cls_a}),
    .is_q (is_q),
    .is_s (is_s),
    .infz (infz)
  );

  fnan_priority u_prio (
    .is_q (is_q),
    .is_s (is_s),
    .infz (infz),
    .rule (rule_sel),
    .pol  (snan_msb_set),
    .hit  (c_hit),
    .sel  (c_sel),
    .inv  (c_inv)
  );

  fnan_result_mux #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_mux (
    .opnd   ({opnd_c, opnd_b, opnd_a}),
    .is_s   (is_s),
    .hit    (c_hit),
    .sel    (c_sel),
    .pol    (snan_msb_set),
    .result (c_res)
  );

  // next-state
  logic              d_valid, d_hit, d_inv;
  logic [1:0]        d_sel;
  logic [WORD_W-1:0] d_res;

  always_comb begin
    d_valid = in_valid;
    d_hit   = out_hit;
    d_sel   = out_sel;
    d_inv   = out_invalid;
    d_res   = out_result;
    if (in_valid) begin
      d_hit = c_hit;
      d_sel = c_sel;
      d_inv = c_inv;
      d_res = c_res;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_hit     <= 1'b0;
      out_sel     <= 2'd0;
      out_invalid <= 1'b0;
      out_result  <= '0;
    end else begin
      out_valid   <= d_valid;
      out_hit     <= d_hit;
      out_sel     <= d_sel;
      out_invalid <= d_inv;
      out_result  <= d_res;
    end
  end

  // assertions
  p_valid_pipe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  p_nan_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (|(is_q | is_s))) |=> out_hit);

  p_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(|(is_q | is_s))) |=> (!out_hit && !out_invalid && out_result == '0));

  p_infz_c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && infz && rule_sel == RULE_2 && is_q[IX_C]) |=> (out_sel == SEL_C && out_invalid));

  p_snan_inv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (|is_s)) |=> out_invalid);

  p_quiet_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hit) |->
      (out_result[WORD_W-2:FRAC_W] == {EXP_W{1'b1}} &&
       out_result[FRAC_W-1] == !$past(snan_msb_set) &&
       out_result[FRAC_W-1:0] != '0));

  p_dflt_pat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hit && out_sel == SEL_DFLT) |->
      (out_result[WORD_W-1] == 1'b0 &&
       out_result[FRAC_W-2:0] == ($past(snan_msb_set) ? {(FRAC_W-1){1'b1}} : {(FRAC_W-1){1'b0}})));
endmodule

// File: tb/sim_fma_nan_select.sv
`timescale 1ns/1ps
module sim_fma_nan_select;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  cls_a, cls_b, cls_c;
  logic [31:0] opnd_a, opnd_b, opnd_c;
  logic [1:0]  rule_sel;
  logic        snan_msb_set;
  logic        out_valid, out_hit, out_invalid;
  logic [1:0]  out_sel;
  logic [31:0] out_result;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  // expected outputs of the last loaded vector
  bit          e_hit, e_inv;
  int          e_sel;
  logic [31:0] e_res;

  always #2.5 clk = ~clk;

  fma_nan_select #(.EXP_W(8), .FRAC_W(23)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .cls_a(cls_a), .cls_b(cls_b), .cls_c(cls_c),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
    .rule_sel(rule_sel), .snan_msb_set(snan_msb_set),
    .out_valid(out_valid), .out_hit(out_hit), .out_sel(out_sel),
    .out_invalid(out_invalid), .out_result(out_result)
  );

  function automatic logic [31:0] dnan(input bit pol);
    return pol ? 32'h7FBF_FFFF : 32'h7FC0_0000;
  endfunction

  function automatic logic [31:0] mkval(input int c, input bit pol, input logic [31:0] r);
    case (c)
      1: return {r[31], 31'd0};
      2: return {r[31], 8'hFF, 23'd0};
      3: return {r[31], 8'hFF, ~pol, r[21:1], 1'b1};
      4: return {r[31], 8'hFF, pol, r[21:1], 1'b1};
      default: return {r[31], 8'h40, r[22:0]};
    endcase
  endfunction

  task automatic ref_model(input int rule, input bit pol, input int c0, input int c1, input int c2,
                           input logic [31:0] v0, input logic [31:0] v1, input logic [31:0] v2);
    bit sn[3], qn[3], nn[3];
    bit infz;
    int cl[3];
    logic [31:0] vv[3];
    cl[0] = c0; cl[1] = c1; cl[2] = c2;
    vv[0] = v0; vv[1] = v1; vv[2] = v2;
    for (int i = 0; i < 3; i++) begin
      sn[i] = (cl[i] == 4);
      qn[i] = (cl[i] == 3);
      nn[i] = sn[i] | qn[i];
    end
    infz = (c0 == 2 && c1 == 1) || (c0 == 1 && c1 == 2);
    e_hit = nn[0] | nn[1] | nn[2];
    e_sel = 0; e_inv = 0; e_res = 32'd0;
    if (!e_hit) return;
    e_inv = sn[0] | sn[1] | sn[2];
    if (rule == 0) begin
      if (infz && qn[2]) begin e_sel = 3; e_inv = 1; end
      else if (sn[2]) e_sel = 2; else if (sn[0]) e_sel = 0; else if (sn[1]) e_sel = 1;
      else if (qn[2]) e_sel = 2; else if (qn[0]) e_sel = 0; else e_sel = 1;
    end else if (rule == 1 && pol) begin
      if (infz) begin e_sel = 3; e_inv = 1; end
      else if (sn[0]) e_sel = 0; else if (sn[1]) e_sel = 1; else if (sn[2]) e_sel = 2;
      else if (qn[0]) e_sel = 0; else if (qn[1]) e_sel = 1; else e_sel = 2;
    end else if (rule == 1) begin
      if (infz) begin e_sel = 2; e_inv = 1; end
      else if (sn[2]) e_sel = 2; else if (sn[0]) e_sel = 0; else if (sn[1]) e_sel = 1;
      else if (qn[2]) e_sel = 2; else if (qn[0]) e_sel = 0; else e_sel = 1;
    end else if (rule == 2) begin
      if (infz) begin e_sel = 2; e_inv = 1; end
      else if (nn[0]) e_sel = 0; else if (nn[2]) e_sel = 2; else e_sel = 1;
    end else begin
      if (nn[0]) e_sel = 0; else if (nn[1]) e_sel = 1; else e_sel = 2;
    end
    if (e_sel == 3) e_res = dnan(pol);
    else if (sn[e_sel]) e_res = pol ? dnan(pol) : (vv[e_sel] | 32'h0040_0000);
    else e_res = vv[e_sel];
  endtask

  task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic [35:0] act, exp;
    act = {out_hit, out_sel, out_invalid, out_result};
    exp = {e_hit, e_sel[1:0], e_inv, e_res};
    check(out_valid && act == exp, tag, act, exp);
  endtask

  // drive at a negedge, check at the next negedge
  task automatic apply(input int rule, input bit pol, input int c0, input int c1, input int c2,
                       input logic [31:0] v0, input logic [31:0] v1, input logic [31:0] v2,
                       input string tag);
    in_valid = 1; rule_sel = rule[1:0]; snan_msb_set = pol;
    cls_a = c0[2:0]; cls_b = c1[2:0]; cls_c = c2[2:0];
    opnd_a = v0; opnd_b = v1; opnd_c = v2;
    ref_model(rule, pol, (c0 > 4) ? 0 : c0, (c1 > 4) ? 0 : c1, (c2 > 4) ? 0 : c2, v0, v1, v2);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic dir(input int rule, input bit pol, input int c0, input int c1, input int c2,
                     input string tag);
    apply(rule, pol, c0, c1, c2, mkval(c0, pol, 32'h0012_3457), mkval(c1, pol, 32'h8023_4569),
          mkval(c2, pol, 32'h0034_567B), tag);
  endtask

  initial begin
    #(200_000 * 5.0);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; rule_sel = 0; snan_msb_set = 0;
    cls_a = 0; cls_b = 0; cls_c = 0; opnd_a = 0; opnd_b = 0; opnd_c = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check({out_valid, out_hit, out_sel, out_invalid, out_result} == 37'd0, "R12",
          {out_hit, out_sel, out_invalid, out_result}, 36'd0);
    rst_n = 1;
    @(negedge clk);
    check(!out_valid, "R1 idle", {35'd0, out_valid}, 36'd0);

    dir(0, 0, 0, 1, 2, "R2 no NaN");
    dir(3, 0, 5, 7, 6, "R2 codes 5..7 normal");
    dir(0, 0, 2, 1, 3, "R3 R8 inf*0 quiet c -> default");
    dir(0, 0, 1, 2, 4, "R3 inf*0 signaling c -> c quieted");
    dir(0, 0, 3, 4, 3, "R3 b signaling beats quiet c");
    dir(0, 0, 3, 3, 0, "R3 quiet a over b");
    dir(1, 1, 2, 1, 3, "R4 inf*0 -> default");
    dir(1, 1, 3, 0, 4, "R4 signaling c over quiet a");
    dir(1, 1, 4, 4, 0, "R4 R10 signaling a -> default word");
    dir(1, 0, 2, 1, 3, "R5 inf*0 -> c");
    dir(1, 0, 4, 0, 4, "R5 signaling c over signaling a");
    dir(2, 0, 3, 0, 3, "R6 a over c");
    dir(2, 0, 0, 3, 0, "R6 b only");
    dir(2, 0, 1, 2, 3, "R6 inf*0 -> c");
    dir(3, 0, 0, 3, 4, "R7 R9 b quiet, c signaling");
    dir(3, 0, 2, 1, 3, "R7 inf*0 no effect");
    dir(3, 1, 0, 0, 4, "R10 R11 signaling c, polarity 1");
    dir(3, 0, 0, 0, 4, "R10 signaling c, polarity 0");

    // R1 hold: in_valid low, inputs change, fields hold
    in_valid = 0; cls_a = 3'd3; opnd_a = 32'h7FC0_1111; rule_sel = 2'd2;
    @(negedge clk);
    check(!out_valid && {out_hit, out_sel, out_invalid, out_result} == {e_hit, e_sel[1:0], e_inv, e_res},
          "R1 hold", {out_hit, out_sel, out_invalid, out_result}, {e_hit, e_sel[1:0], e_inv, e_res});

    for (int n = 0; n < 4000; n++) begin
      int r, c0, c1, c2;
      bit p;
      seed = seed * 32'd1664525 + 32'd1013904223; r = int'(seed[31:30]); p = seed[29];
      c0 = int'(seed[27:24]) % 5; c1 = int'(seed[23:20]) % 5; c2 = int'(seed[19:16]) % 5;
      seed = seed * 32'd1664525 + 32'd1013904223;
      apply(r, p, c0, c1, c2, mkval(c0, p, seed), mkval(c1, p, {seed[15:0], seed[31:16]}),
            mkval(c2, p, ~seed),
            (r == 0) ? "R3 random" : (r == 1) ? (p ? "R4 random" : "R5 random") :
            (r == 2) ? "R6 random" : "R7 random");
    end

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule